// File: doc/BRIEF.md
# System Interrupt Router

This block gathers up to 32 level-sensitive device interrupt lines into a pending register. A disable mask gates those lines. Among the sources that are both pending and enabled, the block finds the highest processor interrupt level and delivers it to one processor, which software selects. Each source bit maps to a 4-bit processor level through a fixed table parameter. The default table gives source i the level ((i*7) mod 15)+1. Several sources may share a level, and the winner is the largest mapped level, not the lowest or highest bit position.

Software uses a small register port indexed by address bits [4:2]. Index 0 reads pending. Index 1 reads the disable mask. Index 2 is a write-one-to-enable port. Index 3 is a write-one-to-disable port, which also discards the pending state of the sources it disables. Index 4 reads and writes the target processor number. The top mask bit (bit 31) is a global kill switch. While it is set, nothing is delivered.

A three-state delivery machine drives the outputs. ST_IDLE moves to ST_FIRE when a deliverable request exists and the target is not busy. It latches the level and target on that move. ST_FIRE pulses the strobe for one cycle and always moves to ST_WAIT. ST_WAIT returns to ST_IDLE when the latched target reports busy or when the request disappears.

Top module: `sys_irq_router`

## Requirements
- R1: After reset, pending reads 0, the disable mask reads 0x004DFF80, the target reads 0 and irq_stb is low.
- R2: A rising source line sets its pending bit. A falling line clears it. A line that stays high does not set the bit again.
- R3: Register index = bus_addr[4:2]. Index 0 reads pending with bit 31 forced to 0, index 1 reads the disable mask, index 4 reads the target, and any other index reads 0.
- R4: A write at index 2 clears every disable bit where (wdata & 0xFFFFFF80) is 1.
- R5: A write at index 3 sets every disable bit where (wdata & 0xFFFFFF80) is 1 and clears the same pending bits. A line still held high leaves that pending bit at 0.
- R6: Disable bits 6:0 never change after reset.
- R7: While disable bit 31 is set, irq_stb stays low whatever is pending.
- R8: irq_level equals the largest table level ((i*7) mod 15)+1 over all bits i that are pending and not disabled.
- R9: A write at index 4 loads wdata[1:0] as the target (4 processors). irq_target carries the target that was selected when the delivery was decided.
- R10: No strobe is issued while cpu_busy[target] is high. Busy bits of other processors have no effect.
- R11: irq_stb is a one-cycle pulse. A persisting request is not delivered again until the target's busy bit has been seen high and then low, or until the request disappears and returns.
- R12: The strobe rises two clock edges after a source line rises. It rises one edge after the write that makes a held request deliverable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Device interrupt lines, level sensitive |
| cpu_busy | input | 4 | Per-processor flag: interrupt already outstanding |
| bus_addr | input | 3 | Register index (address bits 4:2) |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| irq_stb | output | 1 | One-cycle delivery strobe |
| irq_level | output | 4 | Delivered processor level |
| irq_target | output | 2 | Processor that receives the delivery |

## Verification
The register file has one flop stage. The delivery machine adds a second stage, so a source edge shows on irq_stb two edges later. A mask write that completes a request shows one edge after the write cycle. Read data is combinational, so it reflects a write on the first edge after it. The bench drives at falling edges, counts the rising edges between a stimulus and its expected result, and samples at the falling edge where the result is due. Negative checks (masked, globally disabled, busy target) sample the strobe at every falling edge across a window longer than that latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [2:0] {
        IX_PEND    = 3'd0,
        IX_MASK    = 3'd1,
        IX_UNMASK  = 3'd2,
        IX_SETMASK = 3'd3,
        IX_TARGET  = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2
    } dlv_state_e;

    // Default source-to-level map: level(i) = ((i*7) mod 15) + 1, 4 bits each
    function automatic logic [127:0] build_level_map();
        logic [127:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            m[i*4 +: 4] = 4'(((i * 7) % 15) + 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_route_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter int          NUM_CPU   = 4,
    parameter int          CPU_W     = $clog2(NUM_CPU),
    parameter logic [31:0] IMPL_MASK = 32'hFFFF_FF80,
    parameter logic [31:0] RST_DIS   = ~32'hFFB2_007F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [2:0]         bus_addr,
    input  logic               bus_we,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] dis_o,
    output logic [CPU_W-1:0]   tgt_o
);

    localparam logic [NUM_SRC-1:0] WMASK   = IMPL_MASK[NUM_SRC-1:0];
    localparam logic [NUM_SRC-1:0] RDMASK  = {1'b0, {(NUM_SRC-1){1'b1}}};
    localparam logic [NUM_SRC-1:0] FIXBITS = ~WMASK;

    logic [NUM_SRC-1:0] src_q, pend_q, dis_q;
    logic [CPU_W-1:0]   tgt_q;
    logic [NUM_SRC-1:0] rise, fall, wbits, pend_n, dis_n;
    logic               unmask_wr, setmask_wr, tgt_wr;
    reg_idx_e           idx;

    assign idx        = reg_idx_e'(bus_addr);
    assign unmask_wr  = bus_we && (idx == IX_UNMASK);
    assign setmask_wr = bus_we && (idx == IX_SETMASK);
    assign tgt_wr     = bus_we && (idx == IX_TARGET);
    assign wbits      = bus_wdata & WMASK;
    assign rise       = src_lvl & ~src_q;
    assign fall       = ~src_lvl & src_q;

    always_comb begin
        pend_n = (pend_q | rise) & ~fall;
        dis_n  = dis_q;
        if (unmask_wr) begin
            dis_n = dis_q & ~wbits;
        end
        if (setmask_wr) begin
            dis_n  = dis_q | wbits;
            pend_n = pend_n & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
            dis_q  <= RST_DIS[NUM_SRC-1:0];
            tgt_q  <= '0;
        end else begin
            src_q  <= src_lvl;
            pend_q <= pend_n;
            dis_q  <= dis_n;
            if (tgt_wr) begin
                tgt_q <= bus_wdata[CPU_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IX_PEND:   bus_rdata = pend_q & RDMASK;
            IX_MASK:   bus_rdata = dis_q;
            IX_TARGET: bus_rdata = NUM_SRC'(tgt_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign dis_o  = dis_q;
    assign tgt_o  = tgt_q;

    // R5: disabling discards the pending state of the written sources
    a_r5_setmask_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        setmask_wr |=> ((pend_q & $past(wbits)) == '0));

    // R4: enabling clears the written disable bits
    a_r4_unmask_clears_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_wr && !setmask_wr) |=> ((dis_q & $past(wbits)) == '0));

    // R6: unimplemented disable bits hold their value
    a_r6_fixed_bits_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(dis_q & FIXBITS));

endmodule

// File: rtl/irq_level_max.sv
module irq_level_max #(
    parameter int                         NUM_SRC = 32,
    parameter int                         LVL_W   = 4,
    parameter logic [NUM_SRC*LVL_W-1:0]   LVL_MAP = '0
) (
    input  logic [NUM_SRC-1:0] eff,
    output logic [LVL_W-1:0]   lvl_max,
    output logic               any_req
);

    logic [LVL_W-1:0] lvl_of [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        assign lvl_of[g] = eff[g] ? LVL_MAP[g*LVL_W +: LVL_W] : '0;
    end

    always_comb begin
        lvl_max = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (lvl_of[i] > lvl_max) begin
                lvl_max = lvl_of[i];
            end
        end
    end

    assign any_req = |eff;

    // R8: no effective request means no level
    always_comb begin
        a_r8_zero_when_idle: assert (any_req || (lvl_max == '0));
    end

endmodule

// File: rtl/irq_deliver_fsm.sv
module irq_deliver_fsm
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = $clog2(NUM_CPU),
    parameter int LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_ok,
    input  logic [LVL_W-1:0]   lvl_in,
    input  logic [CPU_W-1:0]   tgt_in,
    input  logic [NUM_CPU-1:0] cpu_busy,
    output logic               irq_stb,
    output logic [LVL_W-1:0]   irq_level,
    output logic [CPU_W-1:0]   irq_target
);

    dlv_state_e       state_q, state_n;
    logic [LVL_W-1:0] lvl_q;
    logic [CPU_W-1:0] tgt_q;
    logic             go;

    assign go = req_ok && !cpu_busy[tgt_in];

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_n = ST_FIRE;
            ST_FIRE: state_n = ST_WAIT;
            ST_WAIT: if (cpu_busy[tgt_q] || !req_ok) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && go) begin
                lvl_q <= lvl_in;
                tgt_q <= tgt_in;
            end
        end
    end

    always_comb begin
        irq_stb    = (state_q == ST_FIRE);
        irq_level  = lvl_q;
        irq_target = tgt_q;
    end

    // R11: the strobe is a single-cycle pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |=> !irq_stb);

    // R10: a busy target is never signalled from idle
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_busy[tgt_in]) |=> !irq_stb);

    // R9: the strobe carries the target chosen on the decision edge
    a_r9_target_latched: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |-> (irq_target == $past(tgt_in)));

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import irq_route_pkg::*;
#(
    parameter int                        NUM_SRC   = 32,
    parameter int                        NUM_CPU   = 4,
    parameter int                        LVL_W     = 4,
    parameter logic [31:0]               IMPL_MASK = 32'hFFFF_FF80,
    parameter logic [31:0]               RST_DIS   = ~32'hFFB2_007F,
    parameter logic [NUM_SRC*LVL_W-1:0]  LVL_MAP   = build_level_map(),
    localparam int                       CPU_W     = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_CPU-1:0] cpu_busy,
    input  logic [2:0]         bus_addr,
    input  logic               bus_we,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_stb,
    output logic [LVL_W-1:0]   irq_level,
    output logic [CPU_W-1:0]   irq_target
);

    localparam int GDIS = NUM_SRC - 1;

    logic [NUM_SRC-1:0] pend, dis, eff;
    logic [CPU_W-1:0]   tgt;
    logic [LVL_W-1:0]   lvl_max;
    logic               any_req, req_ok;

    irq_src_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CPU  (NUM_CPU),
        .CPU_W    (CPU_W),
        .IMPL_MASK(IMPL_MASK),
        .RST_DIS  (RST_DIS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pend_o   (pend),
        .dis_o    (dis),
        .tgt_o    (tgt)
    );

    assign eff = pend & ~dis;

    irq_level_max #(
        .NUM_SRC(NUM_SRC),
        .LVL_W  (LVL_W),
        .LVL_MAP(LVL_MAP)
    ) u_max (
        .eff    (eff),
        .lvl_max(lvl_max),
        .any_req(any_req)
    );

    assign req_ok = any_req && !dis[GDIS];

    irq_deliver_fsm #(
        .NUM_CPU(NUM_CPU),
        .CPU_W  (CPU_W),
        .LVL_W  (LVL_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ok    (req_ok),
        .lvl_in    (lvl_max),
        .tgt_in    (tgt),
        .cpu_busy  (cpu_busy),
        .irq_stb   (irq_stb),
        .irq_level (irq_level),
        .irq_target(irq_target)
    );

    // R7: global disable suppresses delivery
    a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        dis[GDIS] |=> !irq_stb);

    // R8: a delivered level is never zero
    a_r8_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |-> (irq_level != '0));

endmodule

// File: tb/tb_sys_irq_router.sv
module tb_sys_irq_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_lvl;
    logic [3:0]  cpu_busy;
    logic [2:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_stb;
    logic [3:0]  irq_level;
    logic [1:0]  irq_target;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_irq_router dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .cpu_busy(cpu_busy),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_stb(irq_stb), .irq_level(irq_level),
        .irq_target(irq_target)
    );

    function automatic logic [3:0] lvl_of(int i);
        return 4'(((i * 7) % 15) + 1);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_lvl = '0; cpu_busy = '0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic rd(logic [2:0] idx, logic [31:0] exp, string tag);
        bus_addr = idx;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] data);
        bus_addr = idx; bus_wdata = data; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic quiet(int n, string tag);
        for (int k = 0; k < n; k++) begin
            tick(1);
            check(tag, 32'(irq_stb), 32'd0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        rd(3'd0, 32'h0, "R1 pending after reset");
        rd(3'd1, 32'h004D_FF80, "R1 mask after reset");
        rd(3'd4, 32'h0, "R1 target after reset");
        check("R1 strobe after reset", 32'(irq_stb), 32'd0);
        rd(3'd5, 32'h0, "R3 unused index reads zero");
    endtask

    task automatic t_pending_edges();
        do_reset();
        cpu_busy = 4'hF;
        src_lvl[9] = 1'b1; src_lvl[31] = 1'b1;
        tick(1);
        rd(3'd0, 32'h0000_0200, "R2 rise sets pend / R3 bit31 hidden");
        src_lvl[9] = 1'b0;
        tick(1);
        rd(3'd0, 32'h0, "R2 fall clears pend");
    endtask

    task automatic t_max_level();
        do_reset();
        src_lvl[0] = 1'b1; src_lvl[3] = 1'b1; src_lvl[5] = 1'b1;
        tick(1);
        check("R12 no strobe after one edge", 32'(irq_stb), 32'd0);
        tick(1);
        check("R12 strobe two edges after rise", 32'(irq_stb), 32'd1);
        check("R8 max of table levels", 32'(irq_level), 32'(lvl_of(3)));
        check("R9 default target", 32'(irq_target), 32'd0);
        quiet(4, "R11 no repeat without busy cycle");
        cpu_busy[0] = 1'b1;
        tick(1);
        cpu_busy[0] = 1'b0;
        tick(1);
        check("R11 refire after busy high then low", 32'(irq_stb), 32'd1);
    endtask

    task automatic t_unmask();
        do_reset();
        src_lvl[8] = 1'b1;
        quiet(4, "R4 masked source silent");
        wr(3'd2, 32'h0000_0100);
        tick(1);
        check("R12 strobe one edge after enable write", 32'(irq_stb), 32'd1);
        check("R8 level of source 8", 32'(irq_level), 32'(lvl_of(8)));
        rd(3'd1, 32'h004D_FE80, "R4 mask bit 8 cleared");
    endtask

    task automatic t_setmask();
        do_reset();
        cpu_busy = 4'hF;
        src_lvl[20] = 1'b1;
        tick(1);
        rd(3'd0, 32'h0010_0000, "R5 pend before disable");
        wr(3'd3, 32'h0010_007F);
        rd(3'd0, 32'h0, "R5 disable clears pend");
        rd(3'd1, 32'h005D_FF80, "R6 low bits unchanged by set");
        tick(3);
        rd(3'd0, 32'h0, "R5 held line not re-pended");
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd1, 32'h0, "R4 enable all implemented");
        wr(3'd3, 32'h0000_007F);
        rd(3'd1, 32'h0, "R6 low bits unchanged by set write");
    endtask

    task automatic t_global();
        do_reset();
        wr(3'd3, 32'h8000_0000);
        src_lvl[20] = 1'b1;
        quiet(5, "R7 global disable blocks");
        wr(3'd2, 32'h8000_0000);
        tick(1);
        check("R7 strobe after global enable", 32'(irq_stb), 32'd1);
        check("R8 level of source 20", 32'(irq_level), 32'(lvl_of(20)));
    endtask

    task automatic t_target_busy();
        do_reset();
        wr(3'd4, 32'hFFFF_FFF6);
        rd(3'd4, 32'h2, "R9 target masked to 2 bits");
        cpu_busy = 4'b0100;
        src_lvl[17] = 1'b1;
        quiet(4, "R10 busy target blocks");
        cpu_busy = 4'b1011;
        tick(1);
        check("R10 others' busy ignored", 32'(irq_stb), 32'd1);
        check("R9 strobe target", 32'(irq_target), 32'd2);
        check("R8 level of source 17", 32'(irq_level), 32'(lvl_of(17)));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pending_edges();
        t_max_level();
        t_unmask();
        t_setmask();
        t_global();
        t_target_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule